// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Sequencer

This block owns the program counter and the flow of instruction words for a small accumulator-style microcontroller core. A synchronous program memory with one cycle of read latency returns one word per cycle. While the word at address A is decoded and executed, the word at A+1 is already being read. Straight-line code therefore retires one instruction per clock.

Any instruction that writes the program counter discards the word that is already in flight. This applies to goto, call, return, and an ALU operation whose destination is the PC-low file register. It costs one bubble cycle, even when the new value equals the sequential address. A taken bit-test-skip also turns the next word into a bubble, but fetch continues sequentially. An eight-entry circular return stack serves call and return. Two counters, one for elapsed cycles and one for retired instructions, let a bench measure the cost of code sequences.

Top module: `fetch_exec_seq`

## Requirements
- R1: In straight-line code (no-op, ALU to accumulator, or a skip that is not taken), each clock executes a valid instruction at `ex_pc`, and the next cycle executes `ex_pc+1`.
- R2: A valid instruction that writes the PC is followed by exactly one bubble cycle (`ex_valid`=0, `ex_bubble`=1), even when the value written equals the sequential address. Such an instruction has word bits [13:11] = 101 (goto), 100 (call) or 010 (return), or bits [13:11] = 001 with bit 7 = 1 and bits [6:0] = 2 (ALU write to PC-low). A chain of three gotos to the next address followed by one no-op spans 7 cycles.
- R3: An ALU word (bits [13:11] = 001) with bit 7 = 0 (accumulator destination), or with bit 7 = 1 and any file address other than 2, takes one cycle and causes no bubble. Words with bits [13:11] = 000, 110 or 111 behave the same way.
- R4: A bit-test-skip word (bits [13:11] = 011) executed while `skip_cond`=1 turns the next cycle into a bubble, and the word after the skipped one executes next, because fetch is not redirected. When `skip_cond`=0, the skip takes one cycle.
- R5: Goto and call replace only the low 11 bits of the PC with word bits [10:0] and keep the upper PC bits of the executing instruction. An ALU write to PC-low replaces the low 8 bits with `alu_result`.
- R6: Call pushes `ex_pc+1` onto the return stack, and return resumes execution at the most recently pushed address.
- R7: The return stack has 8 entries and wraps. A ninth push overwrites the oldest entry, and a pop with no live entries yields the slot that the wrap overwrote. Neither case raises a flag.
- R8: While `rst_n`=0, `imem_addr`=0, `ex_valid`=0, `ex_bubble`=1 and both counters are 0. The first valid execution, at address 0, occurs in the first cycle after the first clock edge with `rst_n`=1.
- R9: `cycle_count` increments on every clock edge after reset. `retire_count` increments only on edges that end a cycle with `ex_valid`=1.
- R10: `ex_class` reports 0 for no-op, 1 for ALU, 2 for ALU to PC-low, 3 for return, 4 for skip, 5 for call and 6 for goto. It reports 0 during a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 13 | Fetch address to program memory |
| imem_rdata | input | 14 | Word read from the address presented one cycle earlier |
| skip_cond | input | 1 | Bit-test result from the datapath; 1 means skip |
| alu_result | input | 8 | ALU result, used when the destination is PC-low |
| ex_valid | output | 1 | The word in execute is live |
| ex_bubble | output | 1 | The execute slot is a flushed or squashed bubble |
| ex_class | output | 3 | Decoded class of the executing word |
| ex_pc | output | 13 | Address of the word in execute |
| cycle_count | output | 16 | Clocks since reset |
| retire_count | output | 16 | Live instructions executed since reset |

## Verification
The bench writes the PC-low register with the value that already comes next, and it jumps to the following address. A design that flushed only when the value changed would show no bubble there, and the goto/no-op chain would come out shorter than 7 cycles. A taken skip sits in front of a goto that must never fire. If the design redirected fetch or executed the squashed word, execution would land at the wrong address. Nine nested calls wrap the return stack, and the bench checks the full return order, including the stale slot seen on underflow. Execution also runs sequentially across a 2K page boundary before a goto, which catches a target that clears the upper PC bits.

// File: rtl/fes_pkg.sv
// Shared opcode field values and execute-class codes for the fetch/execute
// sequencer. Assumes the opcode sits in the top three bits of each word.
package fes_pkg;

    localparam logic [2:0] OP_NOP  = 3'b000;
    localparam logic [2:0] OP_ALU  = 3'b001;
    localparam logic [2:0] OP_RET  = 3'b010;
    localparam logic [2:0] OP_SKIP = 3'b011;
    localparam logic [2:0] OP_CALL = 3'b100;
    localparam logic [2:0] OP_GOTO = 3'b101;

    typedef enum logic [2:0] {
        CL_NOP  = 3'd0,
        CL_ALU  = 3'd1,
        CL_PCW  = 3'd2,
        CL_RET  = 3'd3,
        CL_SKIP = 3'd4,
        CL_CALL = 3'd5,
        CL_GOTO = 3'd6
    } fes_class_e;

endpackage

// File: rtl/fes_decode.sv
// Classifies an instruction word into its flow class. Purely combinational.
// Assumes the caller has split out the opcode, the destination bit and the
// file address.
module fes_decode
    import fes_pkg::*;
#(
    parameter int unsigned FADDR_W  = 7,
    parameter logic [FADDR_W-1:0] PCL_ADDR = 7'h02
) (
    input  logic [2:0]         op,
    input  logic               dest_file,
    input  logic [FADDR_W-1:0] faddr,
    output fes_class_e         cls
);

    // Map the opcode to a class; an ALU op that targets PC-low becomes a PC write.
    always_comb begin
        case (op)
            OP_NOP:  cls = CL_NOP;
            OP_ALU:  cls = (dest_file && (faddr == PCL_ADDR)) ? CL_PCW : CL_ALU;
            OP_RET:  cls = CL_RET;
            OP_SKIP: cls = CL_SKIP;
            OP_CALL: cls = CL_CALL;
            OP_GOTO: cls = CL_GOTO;
            default: cls = CL_ALU;
        endcase
    end

endmodule

// File: rtl/fes_retstack.sv
// Circular hardware return stack. One pointer and no occupancy count: pushes
// past DEPTH overwrite the oldest slot, and pops past empty reread stale slots.
// Assumes DEPTH is a power of two and that push and pop never coincide.
module fes_retstack #(
    parameter int unsigned W     = 13,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_dec;

    assign ptr_dec  = ptr - 1'b1;
    assign top_data = slots[ptr_dec];

    // Move the pointer and store the pushed address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (push) begin
            slots[ptr] <= push_data;
            ptr        <= ptr + 1'b1;
        end else if (pop) begin
            ptr <= ptr_dec;
        end
    end

endmodule

// File: rtl/fes_counters.sv
// Elapsed-cycle and retired-instruction counters for timing measurement.
// Both wrap at their width.
module fes_counters #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    output logic [CNT_W-1:0] cycle_count,
    output logic [CNT_W-1:0] retire_count
);

    // Count every clock, and count the clocks that end with a live execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_count  <= '0;
            retire_count <= '0;
        end else begin
            cycle_count <= cycle_count + 1'b1;
            if (retire) retire_count <= retire_count + 1'b1;
        end
    end

endmodule

// File: rtl/fetch_exec_seq.sv
// Two-stage fetch/execute sequencer. The memory output register acts as the
// instruction register: the word on imem_rdata is the one executing, and
// imem_addr already holds the next sequential address. A PC write loads the
// fetch register, so the word read in the same cycle is dropped as a bubble.
// A taken skip drops that word too but keeps fetching in sequence.
// Assumes a synchronous memory with one cycle of read latency.
module fetch_exec_seq
    import fes_pkg::*;
#(
    parameter int unsigned PC_W     = 13,
    parameter int unsigned IW       = 14,
    parameter int unsigned JMP_W    = 11,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned FADDR_W  = 7,
    parameter logic [FADDR_W-1:0] PCL_ADDR = 7'h02,
    parameter int unsigned RS_DEPTH = 8,
    parameter int unsigned CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [IW-1:0]     imem_rdata,
    input  logic              skip_cond,
    input  logic [DATA_W-1:0] alu_result,
    output logic              ex_valid,
    output logic              ex_bubble,
    output logic [2:0]        ex_class,
    output logic [PC_W-1:0]   ex_pc,
    output logic [CNT_W-1:0]  cycle_count,
    output logic [CNT_W-1:0]  retire_count
);

    localparam int unsigned DEST_BIT = FADDR_W;

    logic [PC_W-1:0] fetch_pc;
    logic [PC_W-1:0] exec_pc;
    logic            live;
    fes_class_e      cls;
    logic            redirect;
    logic            squash;
    logic            push;
    logic            pop;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] stack_top;
    logic [PC_W-1:0] ret_addr;

    fes_decode #(
        .FADDR_W  (FADDR_W),
        .PCL_ADDR (PCL_ADDR)
    ) u_decode (
        .op        (imem_rdata[IW-1 -: 3]),
        .dest_file (imem_rdata[DEST_BIT]),
        .faddr     (imem_rdata[FADDR_W-1:0]),
        .cls       (cls)
    );

    assign ret_addr = exec_pc + 1'b1;

    fes_retstack #(
        .W     (PC_W),
        .DEPTH (RS_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (ret_addr),
        .top_data  (stack_top)
    );

    fes_counters #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire       (live),
        .cycle_count  (cycle_count),
        .retire_count (retire_count)
    );

    // Decide this cycle's flow effect: redirect, squash or sequential.
    always_comb begin
        redirect = 1'b0;
        squash   = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        target   = fetch_pc + 1'b1;
        if (live) begin
            case (cls)
                CL_GOTO: begin
                    redirect = 1'b1;
                    target   = {exec_pc[PC_W-1:JMP_W], imem_rdata[JMP_W-1:0]};
                end
                CL_CALL: begin
                    redirect = 1'b1;
                    push     = 1'b1;
                    target   = {exec_pc[PC_W-1:JMP_W], imem_rdata[JMP_W-1:0]};
                end
                CL_RET: begin
                    redirect = 1'b1;
                    pop      = 1'b1;
                    target   = stack_top;
                end
                CL_PCW: begin
                    redirect = 1'b1;
                    target   = {exec_pc[PC_W-1:DATA_W], alu_result};
                end
                CL_SKIP: squash = skip_cond;
                default: ;
            endcase
        end
    end

    // Advance the fetch address and tag the next word as live or dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc <= '0;
            exec_pc  <= '0;
            live     <= 1'b0;
        end else begin
            fetch_pc <= target;
            exec_pc  <= fetch_pc;
            live     <= !(redirect || squash);
        end
    end

    assign imem_addr = fetch_pc;
    assign ex_valid  = live;
    assign ex_bubble = !live;
    assign ex_pc     = exec_pc;
    assign ex_class  = live ? cls : CL_NOP;

endmodule

// File: rtl/fetch_exec_seq_chk.sv
// Protocol checker for the fetch/execute sequencer, bound to every instance.
module fetch_exec_seq_chk
    import fes_pkg::*;
#(
    parameter int unsigned PC_W  = 13,
    parameter int unsigned JMP_W = 11,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  imem_addr,
    input logic [JMP_W-1:0] jmp_field,
    input logic             skip_cond,
    input logic             ex_valid,
    input logic [2:0]       ex_class,
    input logic [PC_W-1:0]  ex_pc,
    input logic [CNT_W-1:0] cycle_count,
    input logic [CNT_W-1:0] retire_count
);

    logic writes_pc;
    logic seq_op;
    assign writes_pc = (ex_class == CL_GOTO) || (ex_class == CL_CALL) ||
                       (ex_class == CL_RET)  || (ex_class == CL_PCW);
    assign seq_op    = (ex_class == CL_NOP) || (ex_class == CL_ALU) ||
                       ((ex_class == CL_SKIP) && !skip_cond);

    // R1: sequential instructions are followed by the next address, live
    a_r1_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && seq_op) |=> (ex_valid && ex_pc == PC_W'($past(ex_pc) + 1'b1)));

    // R2: any PC write is followed by a bubble
    a_r2_flush_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && writes_pc) |=> !ex_valid);

    // R4: a taken skip bubbles the next slot without redirecting fetch
    a_r4_skip_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_class == CL_SKIP && skip_cond) |=>
        (!ex_valid && imem_addr == PC_W'($past(imem_addr) + 1'b1)));

    // R5: goto keeps the page bits and loads the low field
    a_r5_goto_page: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_class == CL_GOTO) |=>
        (imem_addr == {$past(ex_pc[PC_W-1:JMP_W]), $past(jmp_field)}));

    // R9: retire counter follows live execute cycles
    a_r9_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |=> retire_count == CNT_W'($past(retire_count) + 1'b1));

    a_r9_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |=> $stable(retire_count));

    // R9: cycle counter steps every clock
    a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_count == CNT_W'($past(cycle_count) + 1'b1));

endmodule

bind fetch_exec_seq fetch_exec_seq_chk #(
    .PC_W  (PC_W),
    .JMP_W (JMP_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_addr    (imem_addr),
    .jmp_field    (imem_rdata[JMP_W-1:0]),
    .skip_cond    (skip_cond),
    .ex_valid     (ex_valid),
    .ex_class     (ex_class),
    .ex_pc        (ex_pc),
    .cycle_count  (cycle_count),
    .retire_count (retire_count)
);

// File: tb/fetch_exec_seq_tb_top.sv
module fetch_exec_seq_tb_top;

    localparam int PC_W = 13;
    localparam int IW   = 14;
    localparam int CW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [PC_W-1:0] imem_addr;
    logic [IW-1:0]   imem_rdata;
    logic            skip_cond;
    logic [7:0]      alu_result;
    logic            ex_valid, ex_bubble;
    logic [2:0]      ex_class;
    logic [PC_W-1:0] ex_pc;
    logic [CW-1:0]   cycle_count, retire_count;

    logic [IW-1:0]   mem [256];
    logic [PC_W-1:0] skip_pc = 13'h1FFF;

    int checks = 0;
    int errors = 0;

    fetch_exec_seq dut_i (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .skip_cond(skip_cond), .alu_result(alu_result), .ex_valid(ex_valid),
        .ex_bubble(ex_bubble), .ex_class(ex_class), .ex_pc(ex_pc),
        .cycle_count(cycle_count), .retire_count(retire_count)
    );

    function automatic logic [IW-1:0] w_goto(input logic [10:0] t); return {3'b101, t}; endfunction
    function automatic logic [IW-1:0] w_call(input logic [10:0] t); return {3'b100, t}; endfunction
    localparam logic [IW-1:0] W_NOP  = 14'h0000;
    localparam logic [IW-1:0] W_RET  = {3'b010, 11'd0};
    localparam logic [IW-1:0] W_SKIP = {3'b011, 11'd0};
    localparam logic [IW-1:0] W_ACC  = {3'b001, 3'b000, 1'b0, 7'h05};
    localparam logic [IW-1:0] W_PCL  = {3'b001, 3'b000, 1'b1, 7'h02};

    // Page 0 low 256 words come from mem; above that, one goto at 0x805.
    function automatic logic [IW-1:0] fetch_word(input logic [PC_W-1:0] a);
        if (a[PC_W-1:8] == '0) return mem[a[7:0]];
        if (a == 13'h0805)     return w_goto(11'h010);
        return W_NOP;
    endfunction

    always_ff @(posedge clk) imem_rdata <= fetch_word(imem_addr);

    assign skip_cond = ex_valid && (ex_pc == skip_pc);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = W_NOP;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 reset ex_valid", ex_valid, 0);
        chk("R8 reset ex_bubble", ex_bubble, 1);
        chk("R8 reset imem_addr", imem_addr, 0);
        chk("R8 reset cycle_count", cycle_count, 0);
        chk("R8 reset retire_count", retire_count, 0);
        rst_n = 1'b1;
    endtask

    // Expected trace {valid, class, pc}, one entry per cycle after reset.
    localparam logic [16:0] TRACE [18] = '{
        {1'b1, 3'd0, 13'h000}, {1'b1, 3'd1, 13'h001}, {1'b1, 3'd2, 13'h002},
        {1'b0, 3'd0, 13'h000}, {1'b1, 3'd6, 13'h003}, {1'b0, 3'd0, 13'h000},
        {1'b1, 3'd4, 13'h004}, {1'b0, 3'd0, 13'h000}, {1'b1, 3'd4, 13'h006},
        {1'b1, 3'd5, 13'h007}, {1'b0, 3'd0, 13'h000}, {1'b1, 3'd0, 13'h020},
        {1'b1, 3'd3, 13'h021}, {1'b0, 3'd0, 13'h000}, {1'b1, 3'd6, 13'h008},
        {1'b0, 3'd0, 13'h000}, {1'b1, 3'd6, 13'h030}, {1'b0, 3'd0, 13'h000}
    };

    logic            obs_v  [18];
    logic [PC_W-1:0] obs_pc [18];

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        alu_result = 8'h03;

        // ---- Table-driven trace ----
        clear_mem();
        mem[8'h00] = W_NOP;        mem[8'h01] = W_ACC;
        mem[8'h02] = W_PCL;        mem[8'h03] = w_goto(11'h004);
        mem[8'h04] = W_SKIP;       mem[8'h05] = w_goto(11'h07F);
        mem[8'h06] = W_SKIP;       mem[8'h07] = w_call(11'h020);
        mem[8'h08] = w_goto(11'h030);
        mem[8'h20] = W_NOP;        mem[8'h21] = W_RET;
        mem[8'h30] = w_goto(11'h030);
        skip_pc = 13'h004;
        do_reset();
        for (int k = 0; k < 18; k++) begin
            @(negedge clk);
            obs_v[k]  = ex_valid;
            obs_pc[k] = ex_pc;
            chk("R1 trace ex_valid", ex_valid, TRACE[k][16]);
            chk("R8 trace ex_bubble", ex_bubble, !TRACE[k][16]);
            chk("R10 trace ex_class", ex_class, TRACE[k][15:13]);
            if (TRACE[k][16]) chk("R1 trace ex_pc", ex_pc, TRACE[k][12:0]);
        end
        chk("R9 cycle_count after 18 cycles", cycle_count, 18);
        chk("R9 retire_count after 18 cycles", retire_count, 11);
        chk("R8 first execute at address 0", {obs_v[0], obs_pc[0]}, {1'b1, 13'h000});
        chk("R2 bubble after PC-low write of sequential value", obs_v[3], 0);
        chk("R2 bubble after goto to next address", obs_v[5], 0);
        chk("R3 accumulator ALU has no bubble", {obs_v[2], obs_pc[2]}, {1'b1, 13'h002});
        chk("R4 taken skip bubbles next slot", obs_v[7], 0);
        chk("R4 fetch not redirected by squashed goto", obs_pc[8], 13'h006);
        chk("R4 untaken skip takes one cycle", {obs_v[9], obs_pc[9]}, {1'b1, 13'h007});
        chk("R6 call enters target", obs_pc[11], 13'h020);
        chk("R6 return resumes after call", obs_pc[14], 13'h008);

        // ---- Seven-cycle goto chain ----
        clear_mem();
        mem[0] = w_goto(11'h001); mem[1] = w_goto(11'h002);
        mem[2] = w_goto(11'h003); mem[3] = W_NOP; mem[4] = W_ACC;
        skip_pc = 13'h1FFF;
        do_reset();
        begin
            int k_mark = 0;
            for (int k = 1; k <= 30 && k_mark == 0; k++) begin
                @(negedge clk);
                if (ex_valid && ex_pc == 13'h004) begin
                    k_mark = k;
                    chk("R9 cycle_count at marker", cycle_count, 8);
                    chk("R9 retire_count at marker", retire_count, 4);
                end
            end
            chk("R2 three gotos plus nop span 7 cycles", k_mark - 1, 7);
        end

        // ---- Return stack wrap ----
        clear_mem();
        mem[0] = w_call(11'h020);
        for (int i = 0; i < 8; i++) begin
            mem[8'h20 + 2 * i] = w_call(11'(8'h22 + 2 * i));
            mem[8'h21 + 2 * i] = W_RET;
        end
        mem[8'h30] = W_RET;
        do_reset();
        begin
            logic [PC_W-1:0] exp_ret [9] = '{13'h02F, 13'h02D, 13'h02B, 13'h029,
                                             13'h027, 13'h025, 13'h023, 13'h021, 13'h02F};
            logic prev_ret = 1'b0;
            int n = 0;
            for (int k = 0; k < 120 && n < 9; k++) begin
                @(negedge clk);
                if (ex_valid) begin
                    if (prev_ret) begin
                        chk("R7 return order across wrap", ex_pc, exp_ret[n]);
                        n++;
                    end
                    prev_ret = (ex_class == 3'd3);
                end
            end
            chk("R7 nine returns observed", n, 9);
        end

        // ---- Page-local jump across the 2K boundary ----
        clear_mem();
        mem[0] = w_goto(11'h7FE);
        do_reset();
        begin
            logic seen_goto = 1'b0;
            logic done = 1'b0;
            logic first = 1'b1;
            for (int k = 0; k < 60 && !done; k++) begin
                @(negedge clk);
                if (ex_valid) begin
                    if (first && ex_pc != 13'h000) begin
                        chk("R5 goto low field in page 0", ex_pc, 13'h7FE);
                        first = 1'b0;
                    end
                    if (seen_goto) begin
                        chk("R5 goto keeps page 1 bits", ex_pc, 13'h810);
                        done = 1'b1;
                    end
                    if (ex_pc == 13'h805) seen_goto = 1'b1;
                end
            end
            chk("R5 page test completed", done, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule